// File: doc/BRIEF.md
# Precision Time Counter with Pulse Generators

This block keeps a 64-bit time-of-day value for packet time stamping. A frequency-compensation accumulator adds a software-chosen addend on every reference clock cycle. Each carry out of that accumulator advances the time value by a programmable period, so software can trim the counting rate finely by adjusting the addend. Two alarm comparators watch the time value. Two periodic pulse generators emit one-cycle strobes at a fixed interval of reference cycles. Two capture channels latch the time value on a rising edge of a trigger. Each trigger comes either from an external pin or, in loopback, from the matching pulse generator.

Software reaches everything through one write port and one combinational read port, decoded by a 4-bit address. The control word sits at address 0. Each 64-bit quantity is split across a low and a high word. A write to the low word is staged. The write to the high word commits the full value in one step.

Top module: `ptc_top`

## Requirements
- R1: While enable (control bit 0) is 1, the addend (address 1) is added to a 32-bit accumulator every cycle, and each carry out adds the period field (control bits 25:16) to the time value, which is read at address 2 (low word) and address 3 (high word).
- R2: While enable is 0, neither the accumulator nor the time value changes.
- R3: After reset the control word reads 0x00010000 (period 1, all other bits 0), the time value reads 0, the alarm outputs are low, and the pulse outputs are low.
- R4: A write to address 2 only stages the low word, and the time value does not change. A write to address 3 loads {written word, staged word} into the time value, and the result is readable on the next cycle.
- R5: Writing the high word of an alarm arms it: channel 0 uses addresses 4 (low) and 5 (high), and channel 1 uses addresses 6 and 7. An armed alarm fires once, for one cycle, when the time value is greater than or equal to it. It then stays silent until it is written again. An alarm that was never armed never fires.
- R6: Control bits 1 and 2 set the polarity of alarm outputs 0 and 1. A value of 0 gives active-high and idle-low. A value of 1 gives active-low and idle-high.
- R7: With interval N at address 8 (channel 0) or address 9 (channel 1), a running pulse generator emits a one-cycle pulse every N cycles. A generator whose timer is disabled emits nothing.
- R8: With start mode (control bit 3) at 0, the generators run whenever the timer is enabled. With start mode at 1, they also wait until alarm 0 has fired since the timer was enabled.
- R9: Unless realign-disable (control bit 6) is set, an alarm-0 firing restarts both generators' countdowns, and the next pulse comes N+1 cycles after the alarm output pulse. With realign-disable set, the pulse spacing stays N across the alarm.
- R10: A rising edge on a capture channel's selected input copies the time value into that channel's capture register and sets its sticky flag. Channel 0 reads at addresses 11 (low) and 12 (high), and channel 1 at 13 and 14. The flags are bits 0 and 1 of address 10, and writing 1 to a flag bit clears it.
- R11: Loopback bits (control bits 4 and 5) make capture channel 0 or 1 take its matching pulse output as its input and ignore its external pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 4 | Read address |
| rd_data | output | 32 | Combinational read data |
| trig_i | input | 2 | External capture triggers |
| alarm_o | output | 2 | Alarm outputs, polarity per control bits |
| pulse_o | output | 2 | Periodic pulse outputs |

## Verification
The hardest situation to reach from the ports is an alarm landing in the middle of a running pulse countdown. Only then does realignment show up as a shifted next pulse instead of a pulse that would have come anyway. The stimulus sets the time value to zero and arms the alarm at a value that is reached tens of cycles after enable. It uses an addend of half the accumulator range, so the alarm cycle is known exactly. It then measures the distance from the alarm output to the following pulse, and repeats the run with realignment disabled to show that the pulse spacing is unbroken.

// File: rtl/ptc_pkg.sv
package ptc_pkg;
  localparam int ADDR_W = 4;
  typedef logic [ADDR_W-1:0] addr_t;

  // register addresses; per-channel groups are base + channel offset
  localparam addr_t A_CTRL     = 4'd0;
  localparam addr_t A_ADDEND   = 4'd1;
  localparam addr_t A_CNT_LO   = 4'd2;
  localparam addr_t A_CNT_HI   = 4'd3;
  localparam addr_t A_ALM_BASE = 4'd4;   // lo/hi pairs
  localparam addr_t A_INT_BASE = 4'd8;   // one word per channel
  localparam addr_t A_EVT      = 4'd10;
  localparam addr_t A_CAP_BASE = 4'd11;  // lo/hi pairs

  // control word bit positions
  localparam int B_EN      = 0;
  localparam int B_POL     = 1;   // two bits
  localparam int B_START   = 3;
  localparam int B_LOOP    = 4;   // two bits
  localparam int B_NOALIGN = 6;
  localparam int B_PER     = 16;
endpackage

// File: rtl/ptc_time_base.sv
module ptc_time_base #(
  parameter int ACC_W = 32,
  parameter int CNT_W = 64,
  parameter int PER_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [ACC_W-1:0] addend,
  input  logic [PER_W-1:0] period,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt,
  output logic             carry
);
  logic [ACC_W:0]   sum;
  logic [ACC_W-1:0] acc_q, acc_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    sum   = {1'b0, acc_q} + {1'b0, addend};
    carry = en & sum[ACC_W];
    acc_d = en ? sum[ACC_W-1:0] : acc_q;
    if (load)       cnt_d = load_val;
    else if (carry) cnt_d = cnt_q + CNT_W'(period);
    else            cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      cnt_q <= '0;
    end else begin
      acc_q <= acc_d;
      cnt_q <= cnt_d;
    end
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/ptc_alarm.sv
module ptc_alarm #(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm,
  input  logic [CNT_W-1:0] arm_val,
  input  logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] alm_val,
  output logic             fire
);
  logic [CNT_W-1:0] alm_q, alm_d;
  logic             armed_q, armed_d, fire_q, fire_d;
  logic             reached;

  always_comb begin
    reached = cnt >= alm_q;
    alm_d   = arm ? arm_val : alm_q;
    armed_d = arm | (armed_q & ~reached);
    fire_d  = armed_q & ~arm & reached;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alm_q   <= '0;
      armed_q <= 1'b0;
      fire_q  <= 1'b0;
    end else begin
      alm_q   <= alm_d;
      armed_q <= armed_d;
      fire_q  <= fire_d;
    end
  end

  assign alm_val = alm_q;
  assign fire    = fire_q;
endmodule

// File: rtl/ptc_pulse_gen.sv
module ptc_pulse_gen #(
  parameter int INT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             realign,
  input  logic [INT_W-1:0] interval,
  output logic             pulse
);
  logic [INT_W-1:0] cnt_q, cnt_d, reload;
  logic             pulse_q, pulse_d;

  always_comb begin
    reload  = (interval == '0) ? '0 : interval - INT_W'(1);
    pulse_d = run & ~realign & (cnt_q == '0);
    if (!run)                        cnt_d = reload;
    else if (realign || cnt_q == '0) cnt_d = reload;
    else                             cnt_d = cnt_q - INT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      pulse_q <= pulse_d;
    end
  end

  assign pulse = pulse_q;
endmodule

// File: rtl/ptc_capture.sv
module ptc_capture #(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_in,
  input  logic [CNT_W-1:0] cnt,
  input  logic             clr,
  output logic [CNT_W-1:0] cap,
  output logic             flag
);
  logic [CNT_W-1:0] cap_q, cap_d;
  logic             prev_q, flag_q, flag_d, rise;

  always_comb begin
    rise   = sel_in & ~prev_q;
    cap_d  = rise ? cnt : cap_q;
    flag_d = rise | (flag_q & ~clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      cap_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      prev_q <= sel_in;
      cap_q  <= cap_d;
      flag_q <= flag_d;
    end
  end

  assign cap  = cap_q;
  assign flag = flag_q;
endmodule

// File: rtl/ptc_top.sv
module ptc_top
  import ptc_pkg::*;
#(
  parameter int DW    = 32,
  parameter int ACC_W = 32,
  parameter int PER_W = 10,
  parameter int INT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DW-1:0]     rd_data,
  input  logic [1:0]        trig_i,
  output logic [1:0]        alarm_o,
  output logic [1:0]        pulse_o
);
  localparam int CNT_W = 2 * DW;
  localparam int NCH   = 2;

  // control fields
  logic             tmr_en_q, tmr_en_d, start_q, start_d, noalign_q, noalign_d;
  logic [NCH-1:0]   pol_q, pol_d, loop_q, loop_d;
  logic [PER_W-1:0] period_q, period_d;
  logic [ACC_W-1:0] addend_q, addend_d;
  logic [DW-1:0]    cnt_lo_q, cnt_lo_d;
  logic             seen_q, seen_d;
  logic [DW-1:0]    alm_lo_q [NCH];
  logic [INT_W-1:0] intv_q   [NCH];

  logic             wr_ctrl, cnt_load, carry, run, realign;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] alm_val [NCH];
  logic [CNT_W-1:0] cap_val [NCH];
  logic [NCH-1:0]   fire, pulse, flag;

  assign wr_ctrl  = wr_en && (wr_addr == A_CTRL);
  assign cnt_load = wr_en && (wr_addr == A_CNT_HI);

  always_comb begin
    tmr_en_d  = wr_ctrl ? wr_data[B_EN]            : tmr_en_q;
    pol_d     = wr_ctrl ? wr_data[B_POL +: NCH]    : pol_q;
    start_d   = wr_ctrl ? wr_data[B_START]         : start_q;
    loop_d    = wr_ctrl ? wr_data[B_LOOP +: NCH]   : loop_q;
    noalign_d = wr_ctrl ? wr_data[B_NOALIGN]       : noalign_q;
    period_d  = wr_ctrl ? wr_data[B_PER +: PER_W]  : period_q;
    addend_d  = (wr_en && wr_addr == A_ADDEND) ? wr_data[ACC_W-1:0] : addend_q;
    cnt_lo_d  = (wr_en && wr_addr == A_CNT_LO) ? wr_data : cnt_lo_q;
    // alarm-0 seen since enable: gates the generators in start mode
    seen_d    = tmr_en_q & (seen_q | fire[0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_en_q  <= 1'b0;
      pol_q     <= '0;
      start_q   <= 1'b0;
      loop_q    <= '0;
      noalign_q <= 1'b0;
      period_q  <= PER_W'(1);
      addend_q  <= '0;
      cnt_lo_q  <= '0;
      seen_q    <= 1'b0;
    end else begin
      tmr_en_q  <= tmr_en_d;
      pol_q     <= pol_d;
      start_q   <= start_d;
      loop_q    <= loop_d;
      noalign_q <= noalign_d;
      period_q  <= period_d;
      addend_q  <= addend_d;
      cnt_lo_q  <= cnt_lo_d;
      seen_q    <= seen_d;
    end
  end

  ptc_time_base #(.ACC_W(ACC_W), .CNT_W(CNT_W), .PER_W(PER_W)) u_tb (
    .clk(clk), .rst_n(rst_n), .en(tmr_en_q), .addend(addend_q),
    .period(period_q), .load(cnt_load), .load_val({wr_data, cnt_lo_q}),
    .cnt(cnt), .carry(carry)
  );

  assign run     = tmr_en_q & (~start_q | seen_q);
  assign realign = fire[0] & ~noalign_q;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    localparam addr_t A_LO  = A_ALM_BASE + addr_t'(2 * ch);
    localparam addr_t A_HI  = A_ALM_BASE + addr_t'(2 * ch + 1);
    localparam addr_t A_INT = A_INT_BASE + addr_t'(ch);
    logic wr_lo, wr_int, arm, clr, sel;

    assign wr_lo  = wr_en && (wr_addr == A_LO);
    assign wr_int = wr_en && (wr_addr == A_INT);
    assign arm    = wr_en && (wr_addr == A_HI);
    assign clr    = wr_en && (wr_addr == A_EVT) && wr_data[ch];
    assign sel    = loop_q[ch] ? pulse[ch] : trig_i[ch];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        alm_lo_q[ch] <= '0;
        intv_q[ch]   <= '0;
      end else begin
        if (wr_lo)  alm_lo_q[ch] <= wr_data;
        if (wr_int) intv_q[ch]   <= wr_data[INT_W-1:0];
      end
    end

    ptc_alarm #(.CNT_W(CNT_W)) u_alm (
      .clk(clk), .rst_n(rst_n), .arm(arm), .arm_val({wr_data, alm_lo_q[ch]}),
      .cnt(cnt), .alm_val(alm_val[ch]), .fire(fire[ch])
    );

    ptc_pulse_gen #(.INT_W(INT_W)) u_pg (
      .clk(clk), .rst_n(rst_n), .run(run), .realign(realign),
      .interval(intv_q[ch]), .pulse(pulse[ch])
    );

    ptc_capture #(.CNT_W(CNT_W)) u_cap (
      .clk(clk), .rst_n(rst_n), .sel_in(sel), .cnt(cnt), .clr(clr),
      .cap(cap_val[ch]), .flag(flag[ch])
    );

    assign alarm_o[ch] = fire[ch] ^ pol_q[ch];
    assign pulse_o[ch] = pulse[ch];
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_CTRL: begin
        rd_data[B_EN]            = tmr_en_q;
        rd_data[B_POL +: NCH]    = pol_q;
        rd_data[B_START]         = start_q;
        rd_data[B_LOOP +: NCH]   = loop_q;
        rd_data[B_NOALIGN]       = noalign_q;
        rd_data[B_PER +: PER_W]  = period_q;
      end
      A_ADDEND: rd_data = DW'(addend_q);
      A_CNT_LO: rd_data = cnt[DW-1:0];
      A_CNT_HI: rd_data = cnt[CNT_W-1:DW];
      A_EVT:    rd_data = DW'(flag);
      default:  rd_data = '0;
    endcase
    for (int i = 0; i < NCH; i++) begin
      if (rd_addr == A_ALM_BASE + addr_t'(2 * i))     rd_data = alm_val[i][DW-1:0];
      if (rd_addr == A_ALM_BASE + addr_t'(2 * i + 1)) rd_data = alm_val[i][CNT_W-1:DW];
      if (rd_addr == A_INT_BASE + addr_t'(i))         rd_data = DW'(intv_q[i]);
      if (rd_addr == A_CAP_BASE + addr_t'(2 * i))     rd_data = cap_val[i][DW-1:0];
      if (rd_addr == A_CAP_BASE + addr_t'(2 * i + 1)) rd_data = cap_val[i][CNT_W-1:DW];
    end
  end
endmodule

// File: rtl/ptc_checker.sv
module ptc_checker #(
  parameter int DW    = 32,
  parameter int PER_W = 10
) (
  input logic            clk,
  input logic            rst_n,
  input logic            tmr_en,
  input logic            carry,
  input logic            cnt_load,
  input logic [2*DW-1:0] cnt,
  input logic [PER_W-1:0] period,
  input logic [DW-1:0]   wr_data,
  input logic [1:0]      fire,
  input logic [1:0]      pulse
);
  localparam int CNT_W = 2 * DW;

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_en && carry && !cnt_load |=> cnt == $past(cnt) + CNT_W'($past(period))); // R1
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !tmr_en && !cnt_load |=> $stable(cnt)); // R2
  AST_CNT_LOAD_HI: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_load |=> cnt[CNT_W-1:DW] == $past(wr_data)); // R4
  AST_ALARM0_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    fire[0] |=> !fire[0]); // R5
  AST_ALARM1_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    fire[1] |=> !fire[1]); // R5
  AST_PULSE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !tmr_en |=> pulse == 2'b00); // R7
endmodule

bind ptc_top ptc_checker #(.DW(DW), .PER_W(PER_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tmr_en(tmr_en_q), .carry(carry),
  .cnt_load(cnt_load), .cnt(cnt), .period(period_q), .wr_data(wr_data),
  .fire(fire), .pulse(pulse)
);

// File: tb/tb_ptc_top.sv
`timescale 1ns/1ps
module tb_ptc_top;
  logic        clk, rst_n, wr_en;
  logic [3:0]  wr_addr, rd_addr;
  logic [31:0] wr_data, rd_data;
  logic [1:0]  trig_i, alarm_o, pulse_o;
  int total = 0, bad = 0;
  bit done = 0;

  ptc_top dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .trig_i(trig_i),
    .alarm_o(alarm_o), .pulse_o(pulse_o));

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  typedef struct packed {
    logic [31:0] addend;
    logic [9:0]  per;
    logic [15:0] cyc;
    logic [31:0] exp;
  } vec_t;
  localparam vec_t VEC [6] = '{
    '{32'h8000_0000, 10'd1,  16'd10, 32'd5},
    '{32'h8000_0000, 10'd7,  16'd20, 32'd70},
    '{32'h4000_0000, 10'd10, 16'd16, 32'd40},
    '{32'hFFFF_FFFF, 10'd3,  16'd9,  32'd24},
    '{32'h0000_0000, 10'd5,  16'd12, 32'd0},
    '{32'hC000_0000, 10'd2,  16'd8,  32'd12}
  };

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=0x%0h exp=0x%0h", req, got, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0; trig_i = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    rd_addr = a;
    #1;
    v = rd_data;
  endtask

  task automatic rd64(input logic [3:0] lo, output logic [63:0] v);
    logic [31:0] l, h;
    rd(lo, l);
    rd(lo + 4'd1, h);
    v = {h, l};
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [63:0] v64;
    int n, a, p, np;
    int pidx [16];

    // R1, R2: accumulator/period vectors
    for (int k = 0; k < 6; k++) begin
      do_reset();
      wr(4'd1, VEC[k].addend);
      wr(4'd0, (32'(VEC[k].per) << 16) | 32'h1);
      repeat (int'(VEC[k].cyc) - 1) @(posedge clk);
      wr(4'd0, 32'(VEC[k].per) << 16);
      rd64(4'd2, v64);
      chk($sformatf("R1 vec%0d", k), v64, 64'(VEC[k].exp));
      repeat (5) @(negedge clk);
      rd64(4'd2, v64);
      chk($sformatf("R2 hold vec%0d", k), v64, 64'(VEC[k].exp));
    end

    // R3: reset state
    do_reset();
    rd(4'd0, v);
    chk("R3 ctrl", 64'(v), 64'h0001_0000);
    rd64(4'd2, v64);
    chk("R3 count", v64, 64'd0);
    chk("R3 outputs", {60'd0, alarm_o, pulse_o}, 64'd0);

    // R4: staged low word, atomic commit on high write
    wr(4'd2, 32'h11);
    rd64(4'd2, v64);
    chk("R4 staged", v64, 64'd0);
    wr(4'd3, 32'h22);
    rd64(4'd2, v64);
    chk("R4 commit", v64, 64'h0000_0022_0000_0011);

    // R5, R6: alarms and polarity
    do_reset();
    wr(4'd4, 32'd3);
    wr(4'd5, 32'd0);
    wr(4'd1, 32'h8000_0000);
    wr(4'd0, 32'h0001_0001);
    n = 0; a = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (alarm_o[0]) n++;
      if (alarm_o[1]) a++;
    end
    chk("R5 single fire", 64'(n), 64'd1);
    chk("R5 unarmed silent", 64'(a), 64'd0);
    wr(4'd0, 32'h0001_0007);
    @(negedge clk);
    chk("R6 idle high", 64'(alarm_o), 64'd3);
    n = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (!alarm_o[0]) n++;
    end
    chk("R5 consumed", 64'(n), 64'd0);
    wr(4'd4, 32'd0);
    wr(4'd5, 32'd0);
    n = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (!alarm_o[0]) n++;
    end
    chk("R6 active low rearm", 64'(n), 64'd1);

    // R7: pulse spacing and idle
    do_reset();
    wr(4'd8, 32'd4);
    n = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (pulse_o[0]) n++;
    end
    chk("R7 idle", 64'(n), 64'd0);
    wr(4'd0, 32'h0001_0001);
    np = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (pulse_o[0] && np < 16) begin pidx[np] = i; np++; end
    end
    chk("R7 spacing", 64'(pidx[1] - pidx[0]), 64'd4);
    chk("R7 spacing2", 64'(pidx[2] - pidx[1]), 64'd4);

    // R8: start mode waits for alarm 0
    do_reset();
    wr(4'd8, 32'd3);
    wr(4'd4, 32'd10);
    wr(4'd5, 32'd0);
    wr(4'd1, 32'h8000_0000);
    wr(4'd0, 32'h0001_0009);
    a = -1; p = -1;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (alarm_o[0] && a < 0) a = i;
      if (pulse_o[0] && p < 0) p = i;
    end
    chk("R8 alarm seen", 64'(a >= 0), 64'd1);
    chk("R8 gated until alarm", 64'(p > a), 64'd1);

    // R9: realignment to alarm
    do_reset();
    wr(4'd8, 32'd8);
    wr(4'd4, 32'd10);
    wr(4'd5, 32'd0);
    wr(4'd1, 32'h8000_0000);
    wr(4'd0, 32'h0001_0001);
    a = -1; p = -1;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (alarm_o[0] && a < 0) a = i;
      else if (a >= 0 && pulse_o[0] && p < 0) p = i;
    end
    chk("R9 realign distance", 64'(p - a), 64'd9);
    do_reset();
    wr(4'd8, 32'd8);
    wr(4'd4, 32'd10);
    wr(4'd5, 32'd0);
    wr(4'd1, 32'h8000_0000);
    wr(4'd0, 32'h0001_0041);
    np = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (pulse_o[0] && np < 16) begin pidx[np] = i; np++; end
    end
    n = 0;
    for (int i = 1; i < np; i++) if (pidx[i] - pidx[i-1] != 8) n++;
    chk("R9 no realign spacing", 64'(n), 64'd0);

    // R10: capture from external pins, sticky W1C flags
    do_reset();
    wr(4'd2, 32'h1234);
    wr(4'd3, 32'h5);
    @(negedge clk); trig_i[0] = 1'b1;
    @(negedge clk);
    rd(4'd10, v);
    chk("R10 flag0", 64'(v), 64'd1);
    rd64(4'd11, v64);
    chk("R10 cap0", v64, 64'h0000_0005_0000_1234);
    wr(4'd2, 32'h99);
    wr(4'd3, 32'h0);
    trig_i[0] = 1'b0;
    @(negedge clk); trig_i[1] = 1'b1;
    @(negedge clk);
    rd64(4'd13, v64);
    chk("R10 cap1", v64, 64'h99);
    rd(4'd10, v);
    chk("R10 sticky both", 64'(v), 64'd3);
    wr(4'd10, 32'h1);
    rd(4'd10, v);
    chk("R10 w1c", 64'(v), 64'd2);

    // R11: loopback ignores pin, takes pulse
    do_reset();
    wr(4'd0, 32'h0001_0010);
    @(negedge clk); trig_i[0] = 1'b1;
    repeat (3) @(negedge clk);
    rd(4'd10, v);
    chk("R11 pin ignored", 64'(v), 64'd0);
    wr(4'd8, 32'd3);
    wr(4'd0, 32'h0001_0011);
    repeat (10) @(negedge clk);
    rd(4'd10, v);
    chk("R11 pulse looped", 64'(v), 64'd1);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule